// File: doc/BRIEF.md
# Four-level transition-qualifying phase detector

This block sits behind the data slicers and edge samplers of a four-level (PAM4) serial receiver. It produces the early/late votes that drive a bang-bang clock and data recovery loop. Each cycle it takes one 2-bit symbol decision and the three edge-sampler comparator results for the crossing that led into that symbol. It pairs that symbol with the one before it and decides whether the crossing between them is symmetric about one threshold. A symmetric crossing is one that passes through the threshold midway between its start and end levels.

Only steps between neighbouring levels are voted on. Each is judged with the comparator at the threshold between those two levels. Optionally the block also votes on the full swing between the two outer levels, judged at the centre threshold. A pair with no change in level, or one that jumps two levels, crosses its thresholds off-centre. Such a pair is discarded so that it cannot add dither to the recovered phase. The loop filter and the analog comparators sit outside this block.

Top module: `pam4_edge_qualifier_pd`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, early, late and vote_valid are 0. The first valid symbol after reset gives no vote, because it has no predecessor.
- R2: vote_valid is 1 in the cycle after a valid symbol whose predecessor was valid in the cycle just before it, and 0 otherwise. early and late are only ever 1 together with vote_valid.
- R3: Gray codes map to levels as follows: 00 is level 0 (lowest), 01 is level 1, 11 is level 2 and 10 is level 3. A one-level rising step is judged at the comparator between the two levels: edge_cmp[0] between levels 0 and 1, edge_cmp[1] between 1 and 2, edge_cmp[2] between 2 and 3. If that comparator is 1 (sample above the threshold), late pulses; if it is 0, early pulses. The other two comparators have no effect.
- R4: For a one-level falling step the same comparator is used with the sense reversed. A comparator value of 1 pulses early and 0 pulses late.
- R5: With mode_major = 1, a swing between level 0 (00) and level 3 (10) is judged at edge_cmp[1], with the same rising and falling sense as R3 and R4.
- R6: With mode_major = 0, a swing between level 0 and level 3 gives neither early nor late, whatever the comparators show.
- R7: A repeated symbol, or a two-level jump (level 0 to 2, or 1 to 3, in either direction), gives neither early nor late, whatever the comparators show.
- R8: early and late are never 1 in the same cycle.
- R9: A cycle with sym_valid = 0 breaks the pairing. The next valid symbol gives vote_valid = 0 and no early or late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | A symbol decision is present this cycle |
| sym | input | 2 | Gray-coded level decision of the current symbol |
| edge_cmp | input | 3 | Edge comparators for the crossing into this symbol: [0] low threshold, [1] centre, [2] high threshold; 1 means above |
| mode_major | input | 1 | 1: also vote on the outer-to-outer swing |
| early | output | 1 | One-cycle pulse: sampling clock is early |
| late | output | 1 | One-cycle pulse: sampling clock is late |
| vote_valid | output | 1 | A symbol pair was evaluated in the previous cycle |

## Verification
In every cycle a valid symbol is judged against the stored previous symbol and is also stored as the predecessor for the next cycle. A wrong history update therefore shows up only in the vote for the following symbol. The bench provokes this with long back-to-back runs of symbols, each drawn from a pseudo-random sequence. It also sweeps every ordered level pair with all eight comparator patterns, inserting an idle cycle before each pair, and checks the idle-gap case separately. Each vote is compared against a model computed from the level map. The bench also confirms that the comparators not selected for a pair leave the result unchanged.

// File: rtl/pam4_pd_pkg.sv
// Package: shared widths, the transition kind type and the Gray-to-level
// mapping used by the four-level phase detector.
// Assumes levels are Gray coded 00,01,11,10 from lowest to highest.
package pam4_pd_pkg;
    localparam int SYM_W   = 2;
    localparam int NUM_LVL = 1 << SYM_W;
    localparam int NUM_THR = NUM_LVL - 1;
    localparam int THR_W   = $clog2(NUM_THR);
    localparam int LVL_W   = SYM_W + 1;              // one spare bit for +1 compare
    localparam logic [THR_W-1:0] CENTRE_THR = THR_W'(NUM_THR / 2);

    typedef enum logic [1:0] {
        XN_NONE  = 2'd0,
        XN_MINOR = 2'd1,
        XN_MAJOR = 2'd2
    } xn_kind_t;

    // Converts a Gray-coded symbol to its binary level index.
    function automatic logic [SYM_W-1:0] gray_to_level(input logic [SYM_W-1:0] g);
        logic [SYM_W-1:0] b;
        b[SYM_W-1] = g[SYM_W-1];
        for (int i = SYM_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/pam4_sym_history.sv
// Module: holds the previous symbol and whether it was valid in the cycle
// just before the current one. Assumes an idle cycle breaks the pairing.
module pam4_sym_history
    import pam4_pd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym,
    output logic [SYM_W-1:0] prev_sym,
    output logic             prev_ok
);
    // Record the last symbol and whether it was immediately preceding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sym <= '0;
            prev_ok  <= 1'b0;
        end else begin
            prev_ok <= sym_valid;
            if (sym_valid) begin
                prev_sym <= sym;
            end
        end
    end
endmodule

// File: rtl/pam4_xn_classify.sv
// Module: classifies the crossing between two symbols as a one-level step,
// an outer-to-outer swing or an off-centre crossing. It also reports the
// threshold to judge it at and its direction. Purely combinational.
module pam4_xn_classify
    import pam4_pd_pkg::*;
(
    input  logic [SYM_W-1:0] prev_sym,
    input  logic [SYM_W-1:0] cur_sym,
    output xn_kind_t         kind,
    output logic [THR_W-1:0] thr_idx,
    output logic             rising
);
    logic [SYM_W-1:0] lvl [2];
    logic [LVL_W-1:0] lp;
    logic [LVL_W-1:0] lc;

    // Decode both symbols of the pair to level indices.
    for (genvar k = 0; k < 2; k++) begin : g_dec
        assign lvl[k] = gray_to_level((k == 0) ? prev_sym : cur_sym);
    end

    assign lp = LVL_W'(lvl[0]);
    assign lc = LVL_W'(lvl[1]);

    // Pick the kind of crossing and the threshold that sits midway on it.
    always_comb begin
        kind    = XN_NONE;
        thr_idx = '0;
        rising  = (lc > lp);
        if (lc == lp + 1'b1) begin
            kind    = XN_MINOR;
            thr_idx = THR_W'(lp);
        end else if (lp == lc + 1'b1) begin
            kind    = XN_MINOR;
            thr_idx = THR_W'(lc);
        end else if ((lp == '0 && lc == LVL_W'(NUM_LVL - 1)) ||
                     (lc == '0 && lp == LVL_W'(NUM_LVL - 1))) begin
            kind    = XN_MAJOR;
            thr_idx = CENTRE_THR;
        end
    end
endmodule

// File: rtl/pam4_vote_gen.sv
// Module: turns a classified crossing and the edge comparators into
// registered early/late pulses and a pair-evaluated flag. Assumes the
// comparators belong to the crossing into the current symbol.
module pam4_vote_gen
    import pam4_pd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pair_ok,
    input  xn_kind_t           kind,
    input  logic [THR_W-1:0]   thr_idx,
    input  logic               rising,
    input  logic [NUM_THR-1:0] edge_cmp,
    input  logic               mode_major,
    output logic               early,
    output logic               late,
    output logic               vote_valid
);
    logic take;
    logic sel_cmp;
    logic matches_new;

    // Decide whether this crossing is qualified and which way it votes.
    always_comb begin
        sel_cmp     = edge_cmp[thr_idx];
        take        = pair_ok && ((kind == XN_MINOR) ||
                                  (kind == XN_MAJOR && mode_major));
        matches_new = (sel_cmp == rising);
    end

    // Register the vote so each pulse lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early      <= 1'b0;
            late       <= 1'b0;
            vote_valid <= 1'b0;
        end else begin
            early      <= take && !matches_new;
            late       <= take && matches_new;
            vote_valid <= pair_ok;
        end
    end
endmodule

// File: rtl/pam4_edge_qualifier_pd.sv
// Module: top of the four-level transition-qualifying phase detector.
// Pairs each valid symbol with its predecessor, keeps only symmetric
// crossings and emits one-cycle early/late votes one cycle later.
module pam4_edge_qualifier_pd
    import pam4_pd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_valid,
    input  logic [SYM_W-1:0]   sym,
    input  logic [NUM_THR-1:0] edge_cmp,
    input  logic               mode_major,
    output logic               early,
    output logic               late,
    output logic               vote_valid
);
    logic [SYM_W-1:0] prev_sym;
    logic             prev_ok;
    xn_kind_t         kind;
    logic [THR_W-1:0] thr_idx;
    logic             rising;
    logic             pair_ok;

    assign pair_ok = prev_ok && sym_valid;

    pam4_sym_history u_hist (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .prev_sym(prev_sym), .prev_ok(prev_ok)
    );

    pam4_xn_classify u_cls (
        .prev_sym(prev_sym), .cur_sym(sym),
        .kind(kind), .thr_idx(thr_idx), .rising(rising)
    );

    pam4_vote_gen u_vote (
        .clk(clk), .rst_n(rst_n), .pair_ok(pair_ok), .kind(kind),
        .thr_idx(thr_idx), .rising(rising), .edge_cmp(edge_cmp),
        .mode_major(mode_major), .early(early), .late(late),
        .vote_valid(vote_valid)
    );
endmodule

// File: rtl/pam4_edge_qualifier_pd_chk.sv
// Checker: port-level properties of the phase detector, with its own copy
// of the symbol history. Attached to the top module by bind below.
module pam4_edge_qualifier_pd_chk
    import pam4_pd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sym_valid,
    input logic [SYM_W-1:0]   sym,
    input logic [NUM_THR-1:0] edge_cmp,
    input logic               mode_major,
    input logic               early,
    input logic               late,
    input logic               vote_valid
);
    logic [SYM_W-1:0] c_prev;
    logic             c_ok;
    logic             outer_pair;
    logic             cmp_seen;

    // Track the last symbol independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_prev <= '0;
            c_ok   <= 1'b0;
        end else begin
            c_ok <= sym_valid;
            if (sym_valid) c_prev <= sym;
        end
    end

    assign outer_pair = sym_valid && c_ok &&
        ((c_prev == 2'b00 && sym == 2'b10) || (c_prev == 2'b10 && sym == 2'b00));
    assign cmp_seen = ^edge_cmp;

    assert_one_vote_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(early && late));

    assert_vote_needs_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (early || late) |-> vote_valid);

    assert_idle_breaks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> !vote_valid);

    assert_repeat_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && c_ok && sym == c_prev && (cmp_seen || !cmp_seen)) |=> !(early || late));

    assert_major_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_pair && !mode_major) |=> !(early || late));

    assert_major_voted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_pair && mode_major) |=> (early || late));
endmodule

bind pam4_edge_qualifier_pd pam4_edge_qualifier_pd_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
    .edge_cmp(edge_cmp), .mode_major(mode_major), .early(early),
    .late(late), .vote_valid(vote_valid)
);

// File: tb/pam4_edge_qualifier_pd_tb_top.sv
// Bench: scoreboard. The driver task applies one symbol per cycle and queues
// the expected outputs; a monitor pops and compares them at the falling edge.
module pam4_edge_qualifier_pd_tb_top;
    localparam time CLK_P = 10ns;

    typedef struct {
        logic  e;
        logic  l;
        logic  v;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym = 2'b00;
    logic [2:0] edge_cmp = 3'b000;
    logic       mode_major = 1'b0;
    logic       early, late, vote_valid;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];
    logic m_ok = 1'b0;
    int   m_prev = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_P/2) clk = ~clk;

    pam4_edge_qualifier_pd dut_i (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .edge_cmp(edge_cmp), .mode_major(mode_major),
        .early(early), .late(late), .vote_valid(vote_valid)
    );

    // Level index to Gray code, as listed in R3.
    function automatic logic [1:0] code_of(int lv);
        case (lv)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic check(string tag, logic act, logic expv, string what);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
        end
    endtask

    // Drive one cycle and queue what the outputs must show one cycle later.
    task automatic step(logic v, int lv, logic [2:0] c, logic m);
        exp_t x;
        int   thr;
        logic rise, take;
        @(negedge clk);
        sym_valid  = v;
        sym        = code_of(lv);
        edge_cmp   = c;
        mode_major = m;
        x.e = 1'b0; x.l = 1'b0; x.v = 1'b0;
        if (!v) x.tag = "R9";
        else if (!m_ok) x.tag = "R9/R1";
        else begin
            x.v  = 1'b1;
            rise = (lv > m_prev);
            take = 1'b0;
            thr  = 0;
            if (lv == m_prev + 1 || m_prev == lv + 1) begin
                take  = 1'b1;
                thr   = (lv < m_prev) ? lv : m_prev;
                x.tag = rise ? "R3/R2" : "R4/R2";
            end else if ((lv == 0 && m_prev == 3) || (lv == 3 && m_prev == 0)) begin
                take  = m;
                thr   = 1;
                x.tag = m ? "R5/R2" : "R6/R2";
            end else begin
                x.tag = "R7/R2";
            end
            if (take) begin
                x.l = (c[thr] == rise);
                x.e = !x.l;
            end
        end
        m_ok = v;
        if (v) m_prev = lv;
        @(posedge clk);
        #1;
        q.push_back(x);
    endtask

    // Monitor: compare queued expectations with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                check(x.tag, early, x.e, "early");
                check(x.tag, late, x.l, "late");
                check(x.tag, vote_valid, x.v, "vote_valid");
                check("R8", early & late, 1'b0, "early&late");
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: outputs held low through reset.
        repeat (3) begin
            @(negedge clk);
            sym_valid = 1'b1;
            sym = 2'b01;
            edge_cmp = 3'b111;
            check("R1", early, 1'b0, "early in reset");
            check("R1", late, 1'b0, "late in reset");
            check("R1", vote_valid, 1'b0, "vote_valid in reset");
        end
        @(negedge clk);
        rst_n = 1'b1;
        sym_valid = 1'b0;
        check("R1", vote_valid, 1'b0, "vote_valid after reset");
        // R1: first valid symbol after reset is unpaired.
        step(1'b1, 2, 3'b111, 1'b1);
        step(1'b0, 0, 3'b000, 1'b1);
        // Sweep every ordered pair, all comparator patterns, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 4; p++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int k = 0; k < 8; k++) begin
                        step(1'b0, 0, 3'(~k), m[0]);
                        step(1'b1, p, 3'(~k), m[0]);
                        step(1'b1, c, 3'(k), m[0]);
                    end
                end
            end
        end
        // Back-to-back pseudo-random run with occasional idle cycles.
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:5] != 3'b000, int'(lfsr[1:0]), lfsr[4:2], lfsr[9]);
        end
        step(1'b0, 0, 3'b000, 1'b0);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule